// File: doc/BRIEF.md
# Cycle-Stealing Dual-Address DMA Channel

This block is a single DMA channel that copies a run of transfer units from a source region to a destination region over a shared 16-bit external bus. Each unit is a byte, a word or a longword. Each unit is moved as a read phase from the source followed by a write phase to the destination. A 32-bit holding register carries the data between the two phases.

The channel steals bus cycles. It requests the bus and waits for the grant. It moves exactly one unit and then withdraws its request, so the CPU can run bus cycles before the next unit.

Software programs the following and then pulses start:

- source and destination byte addresses
- a unit count
- a unit size
- an end-of-transfer enable

The channel runs until the count is used up and then raises a done flag that stays set until the next start.

The channel accepts any byte alignment on either side, and the two sides are independent. Each phase is broken into 16-bit bus accesses: word accesses where the address is even and at least two bytes remain, and byte accesses otherwise. Every access lasts two clock cycles.

Top module: `dmacs_channel`

## Requirements
- R1: While reset is held and just after it, bus_req, bus_rd, bus_wr_hi, bus_wr_lo, xfer_end, busy and done are all low.
- R2: A cfg_start pulse while idle with a nonzero cfg_count latches the configuration, clears done and sets busy on the next clock. A cfg_start pulse while busy is ignored: the running transfer completes with its original settings and nothing is written to the addresses of the ignored request.
- R3: A cfg_start pulse while idle with cfg_count equal to zero sets done on the next clock, leaves busy low and never raises bus_req.
- R4: For a transfer of C units of N bytes from source S to destination D, the following hold.
  - Within each unit, all read accesses precede all write accesses, and a read and a write are never active together.
  - After the transfer, byte D+i holds the original byte S+i for every i below C*N.
  - The bytes at D-1 and D+C*N are unchanged.
- R5: Each phase of a unit is split as follows. At offset k, the access is a word if address+k is even and at least two bytes remain; otherwise it is a byte. The offset then advances by 2 or 1. As a result:
  - an even longword takes two words, and an odd longword takes byte, word, byte;
  - an odd word takes two bytes.
- R6: Byte lanes follow the address.
  - An even byte address uses bus bits 15:8 and bus_wr_hi.
  - An odd byte address uses bits 7:0 and bus_wr_lo.
  - A word access drives an even bus_addr with both write strobes.
- R7: Every bus access lasts exactly two clock cycles, with bus_addr and the strobes held for both cycles.
- R8: The channel raises bus_req before a unit and starts the unit's first access only in the cycle after it samples bus_gnt high. It drops bus_req for at least one cycle after each unit's last write. It never drives a strobe while bus_gnt is low.
- R9: After each unit, the source and destination addresses advance by N and the count drops by one. When the count reaches zero, busy falls and done rises.
- R10: When the end-of-transfer enable was set at start, xfer_end is high during every access cycle of the last unit and at no other time. When it was clear, xfer_end stays low.
- R11: cfg_size selects the unit width: 0 is a byte, 1 is a word, and 2 or 3 is a longword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src | input | AW | Source start byte address |
| cfg_dst | input | AW | Destination start byte address |
| cfg_count | input | CW | Number of units to move |
| cfg_size | input | 2 | Unit size code (0 byte, 1 word, 2/3 longword) |
| cfg_end_en | input | 1 | Enable xfer_end for the last unit |
| cfg_start | input | 1 | One-cycle start pulse |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished; held until the next accepted start |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_addr | output | AW | Byte address of the current access |
| bus_rd | output | 1 | Read strobe |
| bus_wr_hi | output | 1 | Write strobe for bits 15:8 (even byte) |
| bus_wr_lo | output | 1 | Write strobe for bits 7:0 (odd byte) |
| bus_rdata | input | 16 | Read data, sampled at the end of the second access cycle |
| bus_wdata | output | 16 | Write data |
| xfer_end | output | 1 | End-of-transfer indication during the last unit |

## Verification
The properties rely on three assumptions about the arbiter and the configuration.

- Once the arbiter raises bus_gnt, it keeps it high until bus_req falls. The bench arbiter is a registered model that grants after a programmable wait and clears the grant as soon as the request drops.
- bus_rdata depends only on bus_addr.
- Source and destination regions do not overlap. The sweep places them in separate windows of a 256-byte memory model.

The sweep covers every combination of unit size and of source and destination address modulo 4, each with one and three units. Grant waits, the end-of-transfer enable and an ignored start in flight are varied across the runs.

// File: rtl/dmacs_pkg.sv
package dmacs_pkg;

  typedef enum logic [2:0] {
    CH_IDLE,
    CH_REQ,
    CH_T1,
    CH_T2,
    CH_REL
  } ch_state_e;

  // Size code to byte count: 0 -> 1, 1 -> 2, 2/3 -> 4
  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dmacs_split.sv
// Chooses byte or word access for the current offset within a unit phase.
module dmacs_split (
  input  logic       addr_odd,
  input  logic [2:0] off,
  input  logic [2:0] nbytes,
  output logic       is_word,
  output logic [2:0] nxt_off,
  output logic       phase_end
);
  logic [2:0] remain;

  always_comb begin
    remain    = nbytes - off;
    is_word   = !addr_odd && (remain >= 3'd2);
    nxt_off   = off + (is_word ? 3'd2 : 3'd1);
    phase_end = (nxt_off == nbytes);
  end
endmodule

// File: rtl/dmacs_hold.sv
// Four-byte holding register, indexed by byte offset within the unit.
module dmacs_hold (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap,
  input  logic        is_word,
  input  logic        addr_odd,
  input  logic [1:0]  off,
  input  logic [15:0] rdata,
  output logic [15:0] wdata
);
  localparam int NB = 4;

  logic [7:0] hb [NB];
  logic [1:0] off_nx;

  assign off_nx = off + 2'd1;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hb[b] <= '0;
      end else if (cap) begin
        if (is_word) begin
          if (off == 2'(b))    hb[b] <= rdata[15:8];
          if (off_nx == 2'(b)) hb[b] <= rdata[7:0];
        end else if (off == 2'(b)) begin
          hb[b] <= addr_odd ? rdata[7:0] : rdata[15:8];
        end
      end
    end
  end

  // Byte accesses put the byte on both lanes; the strobe picks the lane.
  always_comb begin
    wdata[15:8] = hb[off];
    wdata[7:0]  = is_word ? hb[off_nx] : hb[off];
  end
endmodule

// File: rtl/dmacs_ptrs.sv
// Source/destination address and remaining-count registers.
module dmacs_ptrs #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          advance,
  input  logic [2:0]    nbytes,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      dst <= '0;
      cnt <= '0;
    end else if (load) begin
      src <= src_i;
      dst <= dst_i;
      cnt <= cnt_i;
    end else if (advance) begin
      src <= src + AW'(nbytes);
      dst <= dst + AW'(nbytes);
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/dmacs_channel.sv
module dmacs_channel
  import dmacs_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_end_en,
  input  logic          cfg_start,
  output logic          busy,
  output logic          done,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr_hi,
  output logic          bus_wr_lo,
  input  logic [15:0]   bus_rdata,
  output logic [15:0]   bus_wdata,
  output logic          xfer_end
);
  ch_state_e     state;
  logic          rd_phase;
  logic [2:0]    off;
  logic [2:0]    nbytes_q;
  logic          end_en_q;
  logic          busy_q;
  logic          done_q;

  logic [AW-1:0] src, dst, cur_addr;
  logic [CW-1:0] cnt;
  logic          in_acc, is_word, phase_end, load, advance, cap;
  logic [2:0]    nxt_off;

  assign in_acc   = (state == CH_T1) || (state == CH_T2);
  assign cur_addr = rd_phase ? (src + AW'(off)) : (dst + AW'(off));
  assign load     = (state == CH_IDLE) && cfg_start && (cfg_count != '0);
  assign advance  = (state == CH_T2) && !rd_phase && phase_end;
  assign cap      = (state == CH_T2) && rd_phase;

  dmacs_split u_split (
    .addr_odd (cur_addr[0]),
    .off      (off),
    .nbytes   (nbytes_q),
    .is_word  (is_word),
    .nxt_off  (nxt_off),
    .phase_end(phase_end)
  );

  dmacs_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (cap),
    .is_word (is_word),
    .addr_odd(cur_addr[0]),
    .off     (off[1:0]),
    .rdata   (bus_rdata),
    .wdata   (bus_wdata)
  );

  dmacs_ptrs #(.AW(AW), .CW(CW)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .src_i  (cfg_src),
    .dst_i  (cfg_dst),
    .cnt_i  (cfg_count),
    .advance(advance),
    .nbytes (nbytes_q),
    .src    (src),
    .dst    (dst),
    .cnt    (cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CH_IDLE;
      rd_phase <= 1'b1;
      off      <= '0;
      nbytes_q <= 3'd1;
      end_en_q <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      unique case (state)
        CH_IDLE: begin
          if (cfg_start) begin
            done_q <= (cfg_count == '0);
            if (cfg_count != '0) begin
              busy_q   <= 1'b1;
              nbytes_q <= unit_bytes(cfg_size);
              end_en_q <= cfg_end_en;
              rd_phase <= 1'b1;
              off      <= '0;
              state    <= CH_REQ;
            end
          end
        end
        CH_REQ: begin
          if (bus_gnt) state <= CH_T1;
        end
        CH_T1: state <= CH_T2;
        CH_T2: begin
          if (phase_end) begin
            off <= '0;
            if (rd_phase) begin
              rd_phase <= 1'b0;
              state    <= CH_T1;
            end else begin
              rd_phase <= 1'b1;
              state    <= CH_REL;
            end
          end else begin
            off   <= nxt_off;
            state <= CH_T1;
          end
        end
        CH_REL: begin
          if (cnt == '0) begin
            state  <= CH_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            state <= CH_REQ;
          end
        end
        default: state <= CH_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = busy_q;
    done      = done_q;
    bus_req   = (state == CH_REQ) || in_acc;
    bus_addr  = in_acc ? cur_addr : '0;
    bus_rd    = in_acc && rd_phase;
    bus_wr_hi = in_acc && !rd_phase && (is_word || !cur_addr[0]);
    bus_wr_lo = in_acc && !rd_phase && (is_word || cur_addr[0]);
    xfer_end  = in_acc && end_en_q && (cnt == CW'(1));
  end
endmodule

// File: rtl/dmacs_channel_chk.sv
module dmacs_channel_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr_hi,
  input logic          bus_wr_lo,
  input logic          xfer_end
);
  logic wr_any;
  assign wr_any = bus_wr_hi || bus_wr_lo;

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && wr_any)); // R4

  AST_STROBE_HAS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || wr_any) |-> (bus_gnt && bus_req)); // R8

  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_any) |-> !bus_req); // R8

  AST_RD_TWO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |=> (bus_rd && $stable(bus_addr))); // R7

  AST_WR_TWO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_any) |=> (wr_any && $stable(bus_addr))); // R7

  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_hi && bus_wr_lo) |-> !bus_addr[0]); // R6

  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_hi ^ bus_wr_lo) |-> (bus_wr_lo == bus_addr[0])); // R6

  AST_END_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> (bus_rd || wr_any)); // R10

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !bus_req)); // R9

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req); // R3
endmodule

bind dmacs_channel dmacs_channel_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .bus_wr_hi(bus_wr_hi),
  .bus_wr_lo(bus_wr_lo),
  .xfer_end (xfer_end)
);

// File: tb/tb_dmacs_channel.sv
`timescale 1ns/1ps
module tb_dmacs_channel;
  localparam int AW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] cfg_src, cfg_dst;
  logic [CW-1:0] cfg_count;
  logic [1:0]    cfg_size;
  logic          cfg_end_en, cfg_start;
  logic          busy, done, bus_req, bus_gnt;
  logic [AW-1:0] bus_addr;
  logic          bus_rd, bus_wr_hi, bus_wr_lo, xfer_end;
  logic [15:0]   bus_rdata, bus_wdata;

  int nchk = 0;
  int nfail = 0;

  dmacs_channel #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
    .cfg_size(cfg_size), .cfg_end_en(cfg_end_en), .cfg_start(cfg_start),
    .busy(busy), .done(done), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr_hi(bus_wr_hi),
    .bus_wr_lo(bus_wr_lo), .bus_rdata(bus_rdata), .bus_wdata(bus_wdata),
    .xfer_end(xfer_end)
  );

  // 256-byte memory model: even byte on bits 15:8, odd byte on bits 7:0
  logic [7:0] mem [256];
  logic       fill = 1'b0;

  function automatic logic [7:0] fpat(input int i);
    return 8'((i & 255) * 37 + 11);
  endfunction

  always @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < 256; i++) mem[i] <= fpat(i);
    end else begin
      if (bus_wr_hi) mem[{bus_addr[7:1], 1'b0}] <= bus_wdata[15:8];
      if (bus_wr_lo) mem[{bus_addr[7:1], 1'b1}] <= bus_wdata[7:0];
    end
  end
  assign bus_rdata = {mem[{bus_addr[7:1], 1'b0}], mem[{bus_addr[7:1], 1'b1}]};

  // Arbiter model: grants after gdly waiting cycles, holds until request drops
  int gdly = 0;
  int wcnt;
  always @(posedge clk) begin
    if (!rst_n || !bus_req) begin
      bus_gnt <= 1'b0;
      wcnt    <= 0;
    end else if (!bus_gnt) begin
      if (wcnt >= gdly) bus_gnt <= 1'b1;
      else              wcnt    <= wcnt + 1;
    end
  end

  // Bus monitor
  logic clr = 1'b1;
  logic req_d;
  int rd_cyc, wr_cyc, end_cyc, req_falls, req_rises, bad_cyc;
  always @(posedge clk) begin
    if (clr || !rst_n) begin
      rd_cyc <= 0; wr_cyc <= 0; end_cyc <= 0;
      req_falls <= 0; req_rises <= 0; bad_cyc <= 0;
      req_d <= bus_req;
    end else begin
      if (bus_rd) rd_cyc <= rd_cyc + 1;
      if (bus_wr_hi || bus_wr_lo) wr_cyc <= wr_cyc + 1;
      if (xfer_end) end_cyc <= end_cyc + 1;
      if (req_d && !bus_req) req_falls <= req_falls + 1;
      if (!req_d && bus_req) req_rises <= req_rises + 1;
      if ((bus_rd || bus_wr_hi || bus_wr_lo) && !bus_gnt) bad_cyc <= bad_cyc + 1;
      req_d <= bus_req;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Number of bus accesses for one phase (split rule of R5)
  function automatic int nacc(input int a, input int n);
    int k = 0;
    int c = 0;
    while (k < n) begin
      if ((((a + k) & 1) == 0) && (n - k >= 2)) k += 2;
      else k += 1;
      c++;
    end
    return c;
  endfunction

  function automatic int size_bytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  task automatic run_xfer(input int src, input int dst, input int cn, input int sz,
                          input bit en, input int dly, input bit poke);
    int n;
    int nb;
    int bad;
    int first_bad;
    int exp_r;
    int exp_w;
    int exp_e;
    int t;
    n = size_bytes(sz);
    nb = cn * n;
    @(negedge clk);
    fill = 1'b1;
    @(negedge clk);
    fill = 1'b0;
    clr = 1'b1;
    cfg_src = AW'(src); cfg_dst = AW'(dst); cfg_count = CW'(cn);
    cfg_size = 2'(sz); cfg_end_en = en; gdly = dly;
    @(negedge clk);
    clr = 1'b0;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R2 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (6) @(negedge clk);
      cfg_src = 16'd0; cfg_dst = 16'd200; cfg_count = 8'd9; cfg_size = 2'd0;
      cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
    end
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1 && busy == 1'b0, "R9 done and not busy at end", int'(done), 1);
    bad = 0;
    first_bad = -1;
    for (int i = 0; i < nb; i++) begin
      if (mem[dst + i] != fpat(src + i)) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    end
    chk(bad == 0, "R4 R6 data copy mismatching bytes", bad, 0);
    chk(mem[dst - 1] == fpat(dst - 1) && mem[dst + nb] == fpat(dst + nb),
        "R4 guard bytes", int'(mem[dst + nb]), int'(fpat(dst + nb)));
    if (poke)
      chk(mem[200] == fpat(200), "R2 ignored start wrote nothing", int'(mem[200]), int'(fpat(200)));
    exp_r = 0;
    exp_w = 0;
    for (int u = 0; u < cn; u++) begin
      exp_r += nacc(src + u * n, n);
      exp_w += nacc(dst + u * n, n);
    end
    chk(rd_cyc == 2 * exp_r, "R5 R7 read cycles", rd_cyc, 2 * exp_r);
    chk(wr_cyc == 2 * exp_w, "R5 R7 write cycles", wr_cyc, 2 * exp_w);
    chk(req_falls == cn && req_rises == cn, "R8 one request per unit", req_falls, cn);
    chk(bad_cyc == 0, "R8 strobes only under grant", bad_cyc, 0);
    exp_e = en ? 2 * (nacc(src + (cn - 1) * n, n) + nacc(dst + (cn - 1) * n, n)) : 0;
    chk(end_cyc == exp_e, "R10 end-of-transfer cycles", end_cyc, exp_e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R9 watchdog expired: got %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_src = '0; cfg_dst = '0; cfg_count = '0; cfg_size = '0;
    cfg_end_en = 1'b0; cfg_start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_req && !bus_rd && !bus_wr_hi && !bus_wr_lo && !xfer_end && !busy && !done,
        "R1 quiet in reset", int'(bus_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !busy && !done, "R1 quiet after reset", int'(busy), 0);

    // R3: zero count
    clr = 1'b0;
    cfg_count = '0;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    chk(done == 1'b1 && busy == 1'b0, "R3 zero count done", int'(done), 1);
    repeat (5) @(negedge clk);
    chk(req_rises == 0, "R3 zero count no request", req_rises, 0);

    // Sweep: sizes, source/destination address mod 4, one or three units
    for (int sz = 0; sz < 3; sz++)
      for (int sl = 0; sl < 4; sl++)
        for (int dl = 0; dl < 4; dl++)
          for (int c = 0; c < 2; c++)
            run_xfer(16 + sl, 96 + dl, c ? 3 : 1, sz, ((sl + dl + c) & 1) == 1,
                     (sl + dl) % 3, (sz == 2) && (c == 1) && (sl == dl));

    // R11: size code 3 behaves as longword
    run_xfer(17, 98, 2, 3, 1'b1, 1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule